// File: doc/BRIEF.md
# Dithered Sample Word Shortener

This block takes a stream of 24-bit two's complement audio samples for a left and a right channel and shortens each word to 24, 20, 18 or 16 significant bits. A 2-bit select chooses the length. When bits are dropped, the block first adds triangular-PDF dither: the difference of two uniform pseudo-random values, each one target LSB wide, drawn from separate LFSRs per channel. The sum is then truncated. The result stays left-justified in a 24-bit word, with the dropped bits forced to zero.

A source asserts `in_valid` for one cycle with both channel samples present. One clock later the shortened words appear with `out_valid`, and they hold until the next strobe. If dither would push a sample past full scale, that channel saturates to its most positive or most negative code, and its overflow flag is raised for that sample.

Top module: `wlr_dither`

## Requirements
- R1: While `rst` is high and after it falls, before any strobe, `out_valid`, both output words and both overflow flags are 0.
- R2: `out_valid` is high exactly in the cycle after an `in_valid` cycle. With no strobe, the output words and flags hold their values.
- R3: With `wl_sel` = 2'b00 (24 bits), each output word equals its input sample exactly, and the overflow flag is 0.
- R4: `wl_sel` selects the kept length as 2'b01 = 18 bits, 2'b10 = 20 bits and 2'b11 = 16 bits. The 6, 4 or 8 dropped LSBs of the output are 0.
- R5: When reducing, with no overflow, the output equals the input rounded down to a multiple of L = 2^dropped, plus −L, 0 or +L.
- R6: The dither varies from sample to sample. Repeating one mid-range input at 16 bits yields more than one distinct output code.
- R7: If the dithered sum exceeds +2^23−1, the output is 2^23−L and the flag is 1. If the sum is below −2^23, the output is −2^23 (0x800000) and the flag is 1.
- R8: A channel's flag is 0 for any sample that did not saturate. A flag on one channel does not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for both channels |
| wl_sel | input | 2 | Kept length select: 00=24, 01=18, 10=20, 11=16 |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Output strobe, one clock after `in_valid` |
| out_left | output | 24 | Left shortened word, left-justified |
| out_right | output | 24 | Right shortened word, left-justified |
| ovf_left | output | 1 | Left saturation flag for the current output |
| ovf_right | output | 1 | Right saturation flag for the current output |

## Verification
Random samples under random selects check that every reduced output lands within one target LSB of the truncated input, and the 24-bit setting separates exact pass-through from any dithered path. Repeating one mid-scale value at 16 bits shows that the dither actually moves the result, which plain truncation would not do. Inputs pinned at the positive and negative full-scale codes provoke saturation and tell a correct clamp code and flag apart from wrap-around. Driving one channel at full scale while the other sits mid-range shows that the flags are separate.

// File: rtl/wlr_pkg.sv
package wlr_pkg;
  localparam int SAMPLE_W = 24;
  localparam int MAX_DROP = 8;

  typedef enum logic [1:0] {
    WL_FULL = 2'b00,
    WL_18   = 2'b01,
    WL_20   = 2'b10,
    WL_16   = 2'b11
  } wl_sel_e;

  // number of low bits discarded for a select code
  function automatic int unsigned drop_bits(input logic [1:0] sel);
    case (wl_sel_e'(sel))
      WL_18:   return 6;
      WL_20:   return 4;
      WL_16:   return 8;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/wlr_lfsr.sv
module wlr_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (step) state <= {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);
  end

  // a zero state would freeze the dither source (supports R6)
  assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (rst) state != '0);
endmodule

// File: rtl/wlr_channel.sv
module wlr_channel #(
  parameter int DATA_W = wlr_pkg::SAMPLE_W,
  parameter int LFSR_W = 32,
  parameter logic [LFSR_W-1:0] SEED_A = 32'h1,
  parameter logic [LFSR_W-1:0] SEED_B = 32'h2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] y_q,
  output logic              ovf_q
);
  localparam int SW = DATA_W + 2;
  localparam logic signed [SW-1:0] POS_LIM = {3'b000, {(DATA_W-1){1'b1}}};
  localparam logic signed [SW-1:0] NEG_LIM = {3'b111, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] POS_CODE = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [LFSR_W-1:0] st_a, st_b;
  logic [DATA_W-1:0] lowmask, ua, ub, y_d;
  logic signed [SW-1:0] dith, sum;
  logic ovf_d;

  wlr_lfsr #(.W(LFSR_W), .SEED(SEED_A)) u_src_a (
    .clk(clk), .rst(rst), .step(in_valid), .state(st_a));
  wlr_lfsr #(.W(LFSR_W), .SEED(SEED_B)) u_src_b (
    .clk(clk), .rst(rst), .step(in_valid), .state(st_b));

  always_comb begin
    lowmask = ~({DATA_W{1'b1}} << wlr_pkg::drop_bits(sel));
    ua      = st_a[DATA_W-1:0] & lowmask;
    ub      = st_b[DATA_W-1:0] & lowmask;
    dith    = $signed({2'b00, ua}) - $signed({2'b00, ub});
    sum     = $signed({{2{sample[DATA_W-1]}}, sample}) + dith;
    if (sum > POS_LIM) begin
      y_d   = POS_CODE & ~lowmask;
      ovf_d = 1'b1;
    end else if (sum < NEG_LIM) begin
      y_d   = NEG_CODE;
      ovf_d = 1'b1;
    end else begin
      y_d   = sum[DATA_W-1:0] & ~lowmask;
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q   <= '0;
      ovf_q <= 1'b0;
    end else if (in_valid) begin
      y_q   <= y_d;
      ovf_q <= ovf_d;
    end
  end

  assert_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel == 2'b00) |=> (y_q == $past(sample) && !ovf_q));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(y_q) && $stable(ovf_q)));
  assert_clamp_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ovf_d) |=> (y_q == NEG_CODE || y_q[DATA_W-1] == 1'b0));
  assert_no_ovf_full_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel == 2'b00) |=> !ovf_q);
endmodule

// File: rtl/wlr_dither.sv
module wlr_dither #(
  parameter int DATA_W = wlr_pkg::SAMPLE_W,
  parameter int LFSR_W = 32,
  parameter logic [LFSR_W-1:0] SEED_BASE = 32'h1357_9BDF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        wl_sel,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              ovf_left,
  output logic              ovf_right
);
  localparam int NCH = 2;

  logic [DATA_W-1:0] smp [NCH];
  logic [DATA_W-1:0] res [NCH];
  logic              ovf [NCH];

  assign smp[0] = in_left;
  assign smp[1] = in_right;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wlr_channel #(
      .DATA_W(DATA_W), .LFSR_W(LFSR_W),
      .SEED_A(SEED_BASE ^ LFSR_W'(32'h0F1E_2D3C * (2*c + 1))),
      .SEED_B(SEED_BASE ^ LFSR_W'(32'h5A69_7887 * (2*c + 2)))
    ) u_ch (
      .clk(clk), .rst(rst), .in_valid(in_valid), .sel(wl_sel),
      .sample(smp[c]), .y_q(res[c]), .ovf_q(ovf[c]));
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  assign out_left  = res[0];
  assign out_right = res[1];
  assign ovf_left  = ovf[0];
  assign ovf_right = ovf[1];

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_spur_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
endmodule

// File: tb/wlr_dither_test.sv
module wlr_dither_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [1:0] wl_sel = 0;
  logic [23:0] in_left = 0, in_right = 0;
  logic out_valid, ovf_left, ovf_right;
  logic [23:0] out_left, out_right;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  wlr_dither uut (.clk(clk), .rst(rst), .in_valid(in_valid), .wl_sel(wl_sel),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right),
    .ovf_left(ovf_left), .ovf_right(ovf_right));

  function automatic int drop_of(input logic [1:0] s);
    case (s) 2'b01: return 6; 2'b10: return 4; 2'b11: return 8; default: return 0; endcase
  endfunction

  task automatic verdict(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s %s", req, msg); end
  endtask

  task automatic check_ch(input string ch, input logic [23:0] x, input logic [1:0] s,
                          input logic [23:0] y, input logic ov);
    int xs, ys, dr, L, t;
    bit ok;
    xs = $signed(x); ys = $signed(y); dr = drop_of(s); L = 1 << dr;
    t = (xs >>> dr) <<< dr;
    if (dr == 0) begin
      verdict(ys == xs && !ov, "R3",
        $sformatf("%s act y=%h ovf=%0d exp y=%h ovf=0", ch, y, ov, x));
    end else begin
      verdict((ys & (L-1)) == 0, "R4",
        $sformatf("%s act y=%h exp low %0d bits zero", ch, y, dr));
      if (ov) begin
        ok = (xs > 8388607 - L && ys == 8388608 - L) || (xs < -8388608 + L && ys == -8388608);
        verdict(ok, "R7", $sformatf("%s x=%h act y=%h exp clamp code", ch, x, y));
      end else begin
        ok = (ys == t) || (ys == t - L) || (ys == t + L);
        verdict(ok, "R5", $sformatf("%s x=%h act y=%h exp %h +/- %0d", ch, x, y, 24'(t), L));
        ok = !(xs > 8388607 - L) || ys <= 8388608 - L;
        verdict(ok, "R8", $sformatf("%s act ovf=0 y=%h exp in range", ch, y));
      end
    end
  endtask

  task automatic send(input logic [1:0] s, input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    wl_sel = s; in_left = l; in_right = r; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    verdict(out_valid == 1'b1, "R2", $sformatf("act out_valid=%0d exp 1", out_valid));
    check_ch("left", l, s, out_left, ovf_left);
    check_ch("right", r, s, out_right, ovf_right);
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog act hung exp finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] keep_l;
    logic keep_o;
    bit saw_lo, saw_hi, saw_pos, saw_neg;
    int first;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    verdict(out_valid == 0 && out_left == 0 && out_right == 0 && !ovf_left && !ovf_right,
      "R1", $sformatf("act v=%0d l=%h r=%h exp all zero", out_valid, out_left, out_right));
    rst = 0;
    @(negedge clk);
    verdict(out_valid == 0 && out_left == 0 && !ovf_right, "R1", "act nonzero after reset exp zero");

    // R3: pass-through corners
    send(2'b00, 24'h7FFFFF, 24'h800000);
    send(2'b00, 24'h000001, 24'hFFFFFF);

    // R2: hold with no strobe
    send(2'b11, 24'h123456, 24'h654321);
    keep_l = out_left; keep_o = ovf_left;
    @(negedge clk); @(negedge clk);
    verdict(out_valid == 0, "R2", $sformatf("act out_valid=%0d exp 0", out_valid));
    verdict(out_left == keep_l && ovf_left == keep_o, "R2",
      $sformatf("act y=%h exp held %h", out_left, keep_l));

    // R6: dither moves a fixed mid-scale input
    first = -1; saw_lo = 0;
    for (int i = 0; i < 40; i++) begin
      send(2'b11, 24'h100080, 24'h000080);
      if (first < 0) first = out_left;
      else if (out_left != 24'(first)) saw_lo = 1;
    end
    verdict(saw_lo, "R6", "act one output code exp several codes");

    // R7, R8: full-scale saturation on left, right mid-range
    saw_pos = 0; saw_neg = 0;
    for (int i = 0; i < 40; i++) begin
      send(2'b11, 24'h7FFFFF, 24'h001000);
      if (ovf_left) saw_pos = 1;
      verdict(!ovf_right, "R8", $sformatf("act right ovf=%0d exp 0", ovf_right));
    end
    for (int i = 0; i < 40; i++) begin
      send(2'b01, 24'h800000, 24'h800000 + 24'd64);
      if (ovf_left) saw_neg = 1;
    end
    verdict(saw_pos, "R7", "act no positive clamp flag exp at least one");
    verdict(saw_neg, "R7", "act no negative clamp flag exp at least one");

    // random stream, mixed selects
    for (int i = 0; i < 400; i++)
      send(2'($urandom), 24'($urandom), 24'($urandom));

    saw_hi = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule